// File: doc/BRIEF.md
# Two-Stage Output Port Allocator

This block is the output port allocation core of a bufferless mesh router. In every cycle up to four flits arrive, one on each cardinal input (east, west, north, south). Each flit carries a valid bit, an eject flag (the flit is addressed to this node), a setup flag (circuit-path setup traffic), a 2-bit priority, a hop count, a first routing choice and an optional second routing choice. The block sends each flit to exactly one destination: a cardinal output, that input's own local ejection port, or back to the local core.

Allocation is done in two rounds. In the first round each non-ejecting flit competes only for its first choice. In the second round the non-setup losers that have a valid second choice compete for it, provided that output is still free. Flits that are still unplaced are deflected to the remaining free outputs, starting from an offset taken from a free-running LFSR. When there are more of them than free outputs, the worst-ranked ones are returned to the core. A setup flit never deflects. When it wins, it reserves its output for the real-time path until a release arrives. When it loses, it is returned to the core.

All results are registered: the decision for the flits presented in one cycle appears on the outputs after the next rising clock edge.

Top module: `tsa_alloc`

## Requirements
- R1: A valid flit with the eject flag set on input i is granted local ejection port i (grant bit 4+i) and is never returned, whatever the other inputs carry.
- R2: Cardinal output codes are 0 east, 1 west, 2 north, 3 south. Among the flits that request an output, the lowest priority value wins. Among priority-1 flits the largest hop count wins. Remaining ties go to the lowest input index. Both rounds use this rule.
- R3: A setup flit that wins its output reserves it at the same clock edge. From the next presented cycle on, no flit of any kind is granted a reserved output.
- R4: A setup flit that does not win its first choice, including when that output is reserved, raises its return bit and gets no grant.
- R5: A non-setup first-round loser with a valid second choice joins the second round only if that output is neither reserved nor taken in round one. It is granted that output if it wins under the R2 rule.
- R6: Each flit still unplaced after the second round is granted a distinct cardinal output that is neither reserved nor granted in either round.
- R7: When unplaced flits outnumber the free outputs, the lowest-ranked ones under the R2 ordering are returned to the core, one for each missing output.
- R8: Asserting release for an output at a clock edge clears its reservation, so the flits presented in the following cycle may be granted it.
- R9: In each result cycle every output is granted at most once. Every valid flit gets exactly one of a one-hot grant or a return, and an invalid input gets neither.
- R10: While reset is asserted, all grants, returns and reservations are zero.
- R11: The grants and returns for the flits presented in a cycle appear after the next rising edge and hold until the edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flit_vld_i | input | 4 | Flit present on input i |
| flit_eject_i | input | 4 | Flit is addressed to this node |
| flit_setup_i | input | 4 | Flit is circuit-path setup traffic |
| flit_prio_i | input | 4x2 | Priority, 0 highest, 1 aged |
| flit_hop_i | input | 4xHOP_W | Hop count |
| route1_i | input | 4x2 | First routing choice (cardinal code) |
| route2_vld_i | input | 4 | Second routing choice is valid |
| route2_i | input | 4x2 | Second routing choice (cardinal code) |
| release_i | input | 4 | Release the reservation on each cardinal output |
| grant_o | output | 4x8 | One-hot grant per input: bits 0-3 cardinal, 4-7 ejection |
| return_o | output | 4 | Flit is sent back to the local core |

## Verification
Directed patterns separate the cases one by one. Four ejecting flits test whether ejection ever contends. Mixed priorities on a single output test the value ordering, and equal priority-1 flits with different hop counts test the aged hop rule. A pair with a shared first choice and a valid second choice tests whether the second round runs. Two setup flits on one output, followed by traffic aimed at that output, test reservation, return of the setup loser, and release timing. Four flits meeting a reserved output test whether exactly the worst flit is returned. Constrained random traffic then mixes these conditions. The bench checks it against a model that places every flit exactly except for deflections, whose outputs are checked only for being free and distinct.

// File: rtl/tsa_alloc_pkg.sv
package tsa_alloc_pkg;
  localparam int unsigned NUM_IN   = 4;
  localparam int unsigned NUM_CARD = 4;
  localparam int unsigned NUM_OUT  = NUM_CARD + NUM_IN;
  localparam int unsigned PORT_W   = $clog2(NUM_CARD);
  localparam int unsigned IDX_W    = $clog2(NUM_IN);
  localparam int unsigned PRIO_W   = 2;
  localparam int unsigned RANK_W   = $clog2(NUM_IN) + 1;
  localparam logic [PRIO_W-1:0] PRIO_AGED = PRIO_W'(1);
endpackage

// File: rtl/tsa_port_arb.sv
module tsa_port_arb
  import tsa_alloc_pkg::*;
#(
  parameter int unsigned HOP_W = 6
) (
  input  logic [NUM_IN-1:0]             req_i,
  input  logic [NUM_IN-1:0][PRIO_W-1:0] prio_i,
  input  logic [NUM_IN-1:0][HOP_W-1:0]  hop_i,
  output logic [NUM_IN-1:0]             gnt_o
);
  localparam int unsigned KEY_W = PRIO_W + HOP_W + IDX_W;

  logic [KEY_W-1:0] key [NUM_IN];
  logic [KEY_W-1:0] best;
  logic [IDX_W-1:0] sel;
  logic             found;

  // smaller key wins: priority, then inverted hop for aged flits, then index
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      key[i] = {prio_i[i], (prio_i[i] == PRIO_AGED) ? ~hop_i[i] : HOP_W'(0), IDX_W'(i)};
    end
  end

  always_comb begin
    found = 1'b0;
    best  = '1;
    sel   = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (req_i[i] && (!found || key[i] < best)) begin
        found = 1'b1;
        best  = key[i];
        sel   = IDX_W'(i);
      end
    end
    gnt_o = '0;
    if (found) gnt_o[sel] = 1'b1;
  end
endmodule

// File: rtl/tsa_deflect.sv
module tsa_deflect
  import tsa_alloc_pkg::*;
#(
  parameter int unsigned HOP_W = 6
) (
  input  logic [NUM_IN-1:0]               loser_i,
  input  logic [NUM_IN-1:0][PRIO_W-1:0]   prio_i,
  input  logic [NUM_IN-1:0][HOP_W-1:0]    hop_i,
  input  logic [NUM_CARD-1:0]             free_i,
  input  logic [PORT_W-1:0]               rot_i,
  output logic [NUM_IN-1:0][NUM_CARD-1:0] pick_o,
  output logic [NUM_IN-1:0]               drop_o
);
  localparam int unsigned KEY_W = PRIO_W + HOP_W + IDX_W;

  logic [KEY_W-1:0]  key  [NUM_IN];
  logic [RANK_W-1:0] rank [NUM_IN];
  logic [RANK_W-1:0] nfree;

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      key[i] = {prio_i[i], (prio_i[i] == PRIO_AGED) ? ~hop_i[i] : HOP_W'(0), IDX_W'(i)};
    end
  end

  always_comb begin
    nfree = '0;
    for (int o = 0; o < NUM_CARD; o++) nfree = nfree + RANK_W'(free_i[o]);
    for (int i = 0; i < NUM_IN; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NUM_IN; j++) begin
        if (j != i && loser_i[j] && key[j] < key[i]) rank[i] = rank[i] + RANK_W'(1);
      end
    end
  end

  // rank r takes the ((rot + r) mod nfree)-th free output: distinct per loser
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      int slot;
      int seen;
      pick_o[i] = '0;
      drop_o[i] = 1'b0;
      slot = 0;
      seen = 0;
      if (loser_i[i]) begin
        if (rank[i] >= nfree) begin
          drop_o[i] = 1'b1;
        end else begin
          slot = (int'(rot_i) + int'(rank[i])) % int'(nfree);
          for (int o = 0; o < NUM_CARD; o++) begin
            if (free_i[o]) begin
              if (seen == slot) pick_o[i][o] = 1'b1;
              seen = seen + 1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/tsa_resv.sv
module tsa_resv
  import tsa_alloc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CARD-1:0] set_i,
  input  logic [NUM_CARD-1:0] clr_i,
  output logic [NUM_CARD-1:0] res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= (res_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/tsa_lfsr.sv
module tsa_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [15:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= SEED;
    else         state_o <= {state_o[14:0], state_o[15] ^ state_o[14] ^ state_o[12] ^ state_o[3]};
  end
endmodule

// File: rtl/tsa_alloc.sv
module tsa_alloc
  import tsa_alloc_pkg::*;
#(
  parameter int unsigned HOP_W      = 6,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_IN-1:0]                flit_vld_i,
  input  logic [NUM_IN-1:0]                flit_eject_i,
  input  logic [NUM_IN-1:0]                flit_setup_i,
  input  logic [NUM_IN-1:0][PRIO_W-1:0]    flit_prio_i,
  input  logic [NUM_IN-1:0][HOP_W-1:0]     flit_hop_i,
  input  logic [NUM_IN-1:0][PORT_W-1:0]    route1_i,
  input  logic [NUM_IN-1:0]                route2_vld_i,
  input  logic [NUM_IN-1:0][PORT_W-1:0]    route2_i,
  input  logic [NUM_CARD-1:0]              release_i,
  output logic [NUM_IN-1:0][NUM_OUT-1:0]   grant_o,
  output logic [NUM_IN-1:0]                return_o
);
  logic [NUM_CARD-1:0]              res_q, set_res, taken1, taken2, free_out;
  logic [NUM_CARD-1:0][NUM_IN-1:0]  req1, g1, req2, g2;
  logic [NUM_IN-1:0]                fwd, win1, win2, lose1, ret_setup, loser2, drop;
  logic [NUM_IN-1:0][NUM_CARD-1:0]  pick;
  logic [NUM_IN-1:0][NUM_OUT-1:0]   gnt_d;
  logic [NUM_IN-1:0]                ret_d;
  logic [15:0]                      lfsr;

  tsa_resv u_resv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_res),
    .clr_i (release_i),
    .res_o (res_q)
  );

  tsa_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(lfsr)
  );

  // first round: first routing choice only, reserved outputs excluded
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) fwd[i] = flit_vld_i[i] & ~flit_eject_i[i];
    for (int o = 0; o < NUM_CARD; o++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        req1[o][i] = fwd[i] && (route1_i[i] == PORT_W'(o)) && !res_q[o];
      end
    end
  end

  for (genvar o = 0; o < NUM_CARD; o++) begin : g_stage1
    tsa_port_arb #(.HOP_W(HOP_W)) u_arb (
      .req_i (req1[o]),
      .prio_i(flit_prio_i),
      .hop_i (flit_hop_i),
      .gnt_o (g1[o])
    );
  end

  always_comb begin
    win1 = '0;
    for (int o = 0; o < NUM_CARD; o++) begin
      taken1[o]  = |g1[o];
      set_res[o] = |(g1[o] & flit_setup_i);
      win1       = win1 | g1[o];
    end
    lose1     = fwd & ~win1;
    ret_setup = lose1 & flit_setup_i;
    for (int o = 0; o < NUM_CARD; o++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        req2[o][i] = lose1[i] && !flit_setup_i[i] && route2_vld_i[i] &&
                     (route2_i[i] == PORT_W'(o)) && !res_q[o] && !taken1[o];
      end
    end
  end

  for (genvar o = 0; o < NUM_CARD; o++) begin : g_stage2
    tsa_port_arb #(.HOP_W(HOP_W)) u_arb (
      .req_i (req2[o]),
      .prio_i(flit_prio_i),
      .hop_i (flit_hop_i),
      .gnt_o (g2[o])
    );
  end

  always_comb begin
    win2 = '0;
    for (int o = 0; o < NUM_CARD; o++) begin
      taken2[o]   = |g2[o];
      win2        = win2 | g2[o];
      free_out[o] = !res_q[o] && !taken1[o] && !taken2[o];
    end
    loser2 = lose1 & ~flit_setup_i & ~win2;
  end

  tsa_deflect #(.HOP_W(HOP_W)) u_deflect (
    .loser_i(loser2),
    .prio_i (flit_prio_i),
    .hop_i  (flit_hop_i),
    .free_i (free_out),
    .rot_i  (lfsr[PORT_W-1:0]),
    .pick_o (pick),
    .drop_o (drop)
  );

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      gnt_d[i] = '0;
      if (flit_vld_i[i] && flit_eject_i[i]) gnt_d[i][NUM_CARD+i] = 1'b1;
      for (int o = 0; o < NUM_CARD; o++) begin
        if (g1[o][i] || g2[o][i] || pick[i][o]) gnt_d[i][o] = 1'b1;
      end
    end
    ret_d = ret_setup | drop;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o  <= '0;
      return_o <= '0;
    end else begin
      grant_o  <= gnt_d;
      return_o <= ret_d;
    end
  end
endmodule

// File: rtl/tsa_alloc_chk.sv
module tsa_alloc_chk
  import tsa_alloc_pkg::*;
#(
  parameter int unsigned HOP_W = 6
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [NUM_IN-1:0]                flit_vld_i,
  input logic [NUM_IN-1:0]                flit_eject_i,
  input logic [NUM_IN-1:0]                flit_setup_i,
  input logic [NUM_IN-1:0][NUM_OUT-1:0]   grant_o,
  input logic [NUM_IN-1:0]                return_o
);
  logic [NUM_OUT-1:0] col_any;
  logic [NUM_OUT-1:0] col_multi;

  always_comb begin
    col_any   = '0;
    col_multi = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      col_multi = col_multi | (col_any & grant_o[i]);
      col_any   = col_any | grant_o[i];
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r10_reset_quiet: assert (grant_o == '0 && return_o == '0);
    end
  end

  // R9: no output twice per cycle
  a_r9_no_double: assert property (@(posedge clk_i) disable iff (!rst_ni) col_multi == '0);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    // R9: one destination per valid flit, none for idle input
    a_r9_one_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(flit_vld_i[i]) |-> ($countones(grant_o[i]) + 32'(return_o[i])) == 1);
    a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(flit_vld_i[i]) |-> (grant_o[i] == '0 && !return_o[i]));
    // R1: ejecting flit takes own local port
    a_r1_eject: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(flit_vld_i[i] && flit_eject_i[i]) |-> grant_o[i][NUM_CARD+i]);
    // R6: non-ejecting flits never use local ports
    a_r6_cardinal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(flit_vld_i[i] && !flit_eject_i[i]) |-> grant_o[i][NUM_OUT-1:NUM_CARD] == '0);
    for (genvar o = 0; o < NUM_CARD; o++) begin : g_out
      // R3: output won by setup flit is blocked for the next presented cycle
      a_r3_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o[i][o] && $past(flit_setup_i[i] && flit_vld_i[i] && !flit_eject_i[i]))
        |=> !col_any[o]);
    end
  end
endmodule

bind tsa_alloc tsa_alloc_chk #(.HOP_W(HOP_W)) u_chk (.*);

// File: tb/tsa_alloc_test.sv
module tsa_alloc_test;
  localparam int HW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      vld = '0, ej = '0, su = '0, r2v = '0, rel = '0;
  logic [3:0][1:0] pr = '0, r1 = '0, r2 = '0;
  logic [3:0][HW-1:0] hop = '0;
  logic [3:0][7:0] gnt;
  logic [3:0]      ret;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [3:0] res_m = '0, set_m, free_m;
  int         kind [4];   // 0 idle, 1 exact grant, 2 return, 3 deflect
  logic [7:0] exp_g [4];
  string      tagv [4];

  always #4 clk = ~clk;

  tsa_alloc #(.HOP_W(HW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .flit_vld_i(vld), .flit_eject_i(ej), .flit_setup_i(su),
    .flit_prio_i(pr), .flit_hop_i(hop), .route1_i(r1),
    .route2_vld_i(r2v), .route2_i(r2), .release_i(rel),
    .grant_o(gnt), .return_o(ret)
  );

  function automatic int key(int i);
    int hk;
    hk = (pr[i] == 2'd1) ? int'(~hop[i]) : 0;
    return (int'(pr[i]) << (HW + 2)) | (hk << 2) | i;
  endfunction

  function automatic int arb(logic [3:0] req);
    int best = -1;
    for (int i = 0; i < 4; i++)
      if (req[i] && (best < 0 || key(i) < key(best))) best = i;
    return best;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference allocation from R1..R7 for the currently driven inputs
  task automatic model();
    logic [3:0] taken = '0, lose = '0, los2 = '0;
    int nfree = 0;
    set_m = '0;
    for (int i = 0; i < 4; i++) begin kind[i] = 0; exp_g[i] = '0; tagv[i] = ""; end
    for (int i = 0; i < 4; i++)
      if (vld[i] && ej[i]) begin kind[i] = 1; exp_g[i][4+i] = 1'b1; tagv[i] = "R1"; end
    for (int o = 0; o < 4; o++) begin
      logic [3:0] req = '0;
      int w;
      for (int i = 0; i < 4; i++) req[i] = vld[i] && !ej[i] && r1[i] == o[1:0] && !res_m[o];
      w = arb(req);
      if (w >= 0) begin
        kind[w] = 1; exp_g[w][o] = 1'b1; tagv[w] = "R2"; taken[o] = 1'b1;
        if (su[w]) set_m[o] = 1'b1;
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (vld[i] && !ej[i] && kind[i] == 0) begin
        if (su[i]) begin kind[i] = 2; tagv[i] = "R4"; end
        else lose[i] = 1'b1;
      end
    end
    for (int o = 0; o < 4; o++) begin
      logic [3:0] req = '0;
      int w;
      for (int i = 0; i < 4; i++) req[i] = lose[i] && r2v[i] && r2[i] == o[1:0] && !res_m[o] && !taken[o];
      w = arb(req);
      if (w >= 0) begin kind[w] = 1; exp_g[w][o] = 1'b1; tagv[w] = "R5"; lose[w] = 1'b0; end
    end
    for (int o = 0; o < 4; o++) begin
      logic used = 1'b0;
      for (int i = 0; i < 4; i++) if (exp_g[i][o]) used = 1'b1;
      free_m[o] = !res_m[o] && !used;
      if (free_m[o]) nfree++;
    end
    los2 = lose;
    for (int i = 0; i < 4; i++) begin
      if (los2[i]) begin
        int rk = 0;
        for (int j = 0; j < 4; j++) if (j != i && los2[j] && key(j) < key(i)) rk++;
        if (rk >= nfree) begin kind[i] = 2; tagv[i] = "R7"; end
        else begin kind[i] = 3; tagv[i] = "R6"; end
      end
    end
  endtask

  task automatic verify();
    logic [7:0] used = '0;
    for (int i = 0; i < 4; i++) begin
      case (kind[i])
        0: check(gnt[i] == '0 && !ret[i], "R9", $sformatf("idle in%0d", i), {gnt[i], 7'b0, ret[i]}, 0);
        1: check(gnt[i] == exp_g[i] && !ret[i], tagv[i], $sformatf("grant in%0d", i), {gnt[i], 7'b0, ret[i]}, {exp_g[i], 8'h0});
        2: check(gnt[i] == '0 && ret[i], tagv[i], $sformatf("return in%0d", i), {gnt[i], 7'b0, ret[i]}, 1);
        default: check($countones(gnt[i]) == 1 && gnt[i][7:4] == '0 && (gnt[i][3:0] & ~free_m) == '0 && !ret[i],
                       "R6", $sformatf("deflect in%0d", i), {gnt[i], 7'b0, ret[i]}, {4'h0, free_m});
      endcase
      check((used & gnt[i]) == '0, "R9", $sformatf("double grant in%0d", i), gnt[i], 0);
      used = used | gnt[i];
    end
  endtask

  // drive is done; compute, cross the edge, check at the next falling edge
  task automatic cycle();
    model();
    @(negedge clk);
    verify();
    res_m = (res_m & ~rel) | set_m;
  endtask

  task automatic flit(int i, bit e, bit s, int p, int h, int a, bit bv, int b);
    vld[i] = 1'b1; ej[i] = e; su[i] = s; pr[i] = p[1:0]; hop[i] = h[HW-1:0];
    r1[i] = a[1:0]; r2v[i] = bv; r2[i] = b[1:0];
  endtask

  task automatic clear();
    vld = '0; ej = '0; su = '0; r2v = '0; rel = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(gnt == '0 && ret == '0, "R10", "outputs in reset", {gnt, ret}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gnt == '0 && ret == '0, "R10", "outputs after reset", {gnt, ret}, 0);

    // R1: all four eject at once
    clear();
    for (int i = 0; i < 4; i++) flit(i, 1, 0, 3, 0, 0, 0, 0);
    cycle();
    // R11: new inputs do not change outputs before the edge
    clear();
    #1;
    check(gnt[0] == 8'h10 && gnt[3] == 8'h80, "R11", "hold until edge", gnt, 32'h80402010);
    cycle();

    // R2: priority value ordering, tie on index
    clear();
    flit(0, 0, 0, 3, 0, 2, 0, 0);
    flit(1, 0, 0, 2, 0, 2, 0, 0);
    flit(2, 0, 0, 2, 0, 2, 0, 0);
    cycle();
    check(gnt[1] == 8'h04, "R2", "lowest priority value wins", gnt[1], 8'h04);

    // R2: aged flits, largest hop wins
    clear();
    flit(0, 0, 0, 1, 3, 0, 0, 0);
    flit(1, 0, 0, 1, 9, 0, 0, 0);
    flit(2, 0, 0, 1, 9, 0, 0, 0);
    flit(3, 0, 0, 1, 2, 0, 0, 0);
    cycle();
    check(gnt[1] == 8'h01, "R2", "largest hop wins", gnt[1], 8'h01);

    // R5: second round
    clear();
    flit(0, 0, 0, 2, 0, 0, 0, 0);
    flit(1, 0, 0, 3, 0, 0, 1, 2);
    cycle();
    check(gnt[1] == 8'h04, "R5", "second choice granted", gnt[1], 8'h04);

    // R3/R4: two setup flits on west
    clear();
    flit(2, 0, 1, 0, 0, 1, 0, 0);
    flit(3, 0, 1, 0, 0, 1, 0, 0);
    cycle();
    check(ret[3] && gnt[3] == '0, "R4", "setup loser returned", {gnt[3], ret[3]}, 1);
    clear();
    flit(0, 0, 0, 2, 0, 1, 0, 0);
    cycle();
    check(gnt[0][1] == 1'b0, "R3", "reserved west not granted", gnt[0], 0);

    // R7: four flits, west reserved, east contested
    clear();
    flit(0, 0, 0, 2, 0, 0, 0, 0);
    flit(1, 0, 0, 3, 0, 0, 0, 0);
    flit(2, 0, 0, 1, 5, 0, 0, 0);
    flit(3, 0, 0, 3, 0, 0, 0, 0);
    cycle();
    check(ret == 4'b1000, "R7", "worst flit returned", ret, 4'b1000);

    // R8: release, then west usable
    clear();
    rel = 4'b0010;
    cycle();
    clear();
    flit(1, 0, 0, 3, 0, 1, 0, 0);
    cycle();
    check(gnt[1] == 8'h02, "R8", "released west granted", gnt[1], 8'h02);

    // constrained random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      clear();
      for (int i = 0; i < 4; i++) begin
        if ($urandom_range(0, 9) < 7) begin
          bit e = ($urandom_range(0, 5) == 0);
          bit s = !e && ($urandom_range(0, 15) == 0);
          flit(i, e, s, s ? 0 : int'($urandom_range(1, 3)), int'($urandom_range(0, 63)),
               int'($urandom_range(0, 3)), $urandom_range(0, 1) == 1, int'($urandom_range(0, 3)));
        end
      end
      rel = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      cycle();
    end

    clear();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule